// File: doc/BRIEF.md
# Reference-Window Clock Rate Meter

The block measures the frequency of an unknown clock by counting its rising edges while a window of reference ticks runs. The reference ticks come from the block's own clock (a crystal clock) divided by `REF_DIV`. With the default of four and a 19.2 MHz crystal, one tick is 1/4.8 MHz.

Software drives a single control word and reads a single status word. The control word holds a window length and a run-enable bit. The status word holds the captured edge count and one flag bit. The flag's meaning depends on the enable bit:
- With enable clear, a set flag means the measured domain has not yet stopped.
- With enable set, a set flag means the window has expired and the result is held.

The intended sequence is:
1. Write zero.
2. Wait for the flag to clear.
3. Write the length with enable clear.
4. Write the length with enable set.
5. Wait for the flag to rise.
6. Read the count.
7. Write zero again.

The measured-domain counter is cleared only on an edge of the measured clock. A clock that is not toggling therefore leaves the previous result in place, and software can spot a dead clock by running two windows and comparing the counts. The interface is a plain register strobe with no back-pressure: a write is taken on every cycle in which `ctl_wr` is high.

Top module: `clk_rate_meter`

## Requirements
- R1: After reset the status word reads all zeros.
- R2: A write with enable (control bit 20) clear and a length in bits 19:0 starts nothing. The flag stays at its ready value and the count field is unchanged.
- R3: A write with bit 20 set while enable was clear opens a window of max(length,1) × REF_DIV clock cycles. Status bit 25 reads 0 throughout the window.
- R4: Once the window has expired and the measured domain has stopped, status bit 25 reads 1 while enable stays set. The count field, status bits 24:0, changes only in the cycle that bit 25 rises.
- R5: The captured count differs from (window duration / measured clock period) by at most 2.
- R6: With enable clear, status bit 25 reads 1 while the measured domain is still running and 0 once it has stopped (ready).
- R7: If the measured clock does not toggle during a run, the run still completes and the count field repeats the previous result.
- R8: A write with enable clear in the middle of a window stops the window at the next edge. Bit 25 does not report completion and the count field keeps its old value.
- R9: A write with enable set while enable is already set is ignored: the running window keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; reference domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| meas_clk | input | 1 | Clock being measured |
| ctl_wr | input | 1 | Control write strobe, one cycle per write |
| ctl_wdata | input | WIN_W+1 | Bit WIN_W enable, bits WIN_W-1:0 window length |
| stat_rdata | output | CNT_W+1 | Bit CNT_W flag, bits CNT_W-1:0 captured count |

## Verification
A down-counter that loses a tick or reloads on a repeated enable write moves the rise of the flag by whole reference ticks. It also shifts the count by roughly the measured-to-reference frequency ratio per tick, which shows at the first completed window. A capture taken before the measured domain stops, or a counter that is never cleared, shows up as a count outside the two-edge tolerance, or as a changed count after a dead-clock run. A wrong flag encoding shows within a few cycles of any write, as a flag that is set during an open window or does not clear after a stop.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_OPEN = 2'd1,
    WS_DRAIN = 2'd2,
    WS_HELD = 2'd3
  } win_state_e;
endpackage

// File: rtl/fcm_sync.sv
module fcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fcm_edge_cnt.sv
module fcm_edge_cnt #(
  parameter int CNT_W       = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             run_ref,
  output logic             busy_m,
  output logic [CNT_W-1:0] edges
);
  logic run_m;
  logic run_m_d;

  fcm_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(mclk), .rst_n(rst_n), .d(run_ref), .q(run_m)
  );

  // Only edges of mclk clear or advance the count: a dead clock leaves it stale.
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      run_m_d <= 1'b0;
      edges   <= '0;
    end else begin
      run_m_d <= run_m;
      if (run_m && !run_m_d) edges <= '0;
      else if (run_m)        edges <= edges + 1'b1;
    end
  end

  assign busy_m = run_m_d;
endmodule

// File: rtl/fcm_window.sv
module fcm_window
  import fcm_pkg::*;
#(
  parameter int WIN_W   = 20,
  parameter int CNT_W   = 25,
  parameter int REF_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIN_W-1:0] wr_len,
  input  logic             wr_en,
  input  logic             busy_sync,
  input  logic [CNT_W-1:0] edges_m,
  output logic             run_q,
  output logic             en_q,
  output logic             flag,
  output logic [CNT_W-1:0] result
);
  localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);

  win_state_e       state;
  logic [DIV_W-1:0] prescale;
  logic [WIN_W-1:0] remain;
  logic             start;
  logic             tick;

  assign start = wr && wr_en && !en_q;
  assign tick  = (prescale == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (wr) en_q <= wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WS_IDLE;
      run_q    <= 1'b0;
      prescale <= '0;
      remain   <= '0;
      result   <= '0;
    end else if (wr && !wr_en) begin
      state <= WS_IDLE;
      run_q <= 1'b0;
    end else if (start) begin
      state    <= WS_OPEN;
      run_q    <= 1'b1;
      prescale <= '0;
      remain   <= wr_len;
    end else begin
      case (state)
        WS_OPEN: begin
          if (tick) begin
            prescale <= '0;
            if (remain <= WIN_W'(1)) begin
              state <= WS_DRAIN;
              run_q <= 1'b0;
            end else begin
              remain <= remain - 1'b1;
            end
          end else begin
            prescale <= prescale + 1'b1;
          end
        end
        WS_DRAIN: begin
          // Count is quasi-static once the measured side reports stopped.
          if (!busy_sync) begin
            state  <= WS_HELD;
            result <= edges_m;
          end
        end
        default: ;
      endcase
    end
  end

  assign flag = (state == WS_HELD) || ((state == WS_IDLE) && busy_sync);
endmodule

// File: rtl/clk_rate_meter.sv
module clk_rate_meter #(
  parameter int WIN_W       = 20,
  parameter int CNT_W       = 25,
  parameter int REF_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_clk,
  input  logic             ctl_wr,
  input  logic [WIN_W:0]   ctl_wdata,
  output logic [CNT_W:0]   stat_rdata
);
  localparam int EN_BIT = WIN_W;

  logic             run_q;
  logic             en_q;
  logic             busy_m;
  logic             busy_sync;
  logic             flag;
  logic [CNT_W-1:0] edges_m;
  logic [CNT_W-1:0] result;

  fcm_window #(.WIN_W(WIN_W), .CNT_W(CNT_W), .REF_DIV(REF_DIV)) u_window (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr),
    .wr_len(ctl_wdata[WIN_W-1:0]), .wr_en(ctl_wdata[EN_BIT]),
    .busy_sync(busy_sync), .edges_m(edges_m),
    .run_q(run_q), .en_q(en_q), .flag(flag), .result(result)
  );

  fcm_edge_cnt #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_edges (
    .mclk(meas_clk), .rst_n(rst_n), .run_ref(run_q),
    .busy_m(busy_m), .edges(edges_m)
  );

  fcm_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .d(busy_m), .q(busy_sync)
  );

  assign stat_rdata = {flag, result};
endmodule

// File: rtl/clk_rate_meter_chk.sv
module clk_rate_meter_chk #(
  parameter int WIN_W = 20,
  parameter int CNT_W = 25
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_wr,
  input logic [WIN_W:0] ctl_wdata,
  input logic [CNT_W:0] stat_rdata,
  input logic           run_q,
  input logic           en_q
);
  AST_ABORT_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wdata[WIN_W] |=> !run_q); // R8

  AST_START_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[WIN_W] && !en_q |=> run_q); // R3

  AST_FLAG_LOW_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !stat_rdata[CNT_W]); // R3

  AST_COUNT_MOVES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_rdata[CNT_W-1:0]) |-> $rose(stat_rdata[CNT_W])); // R4

  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[CNT_W]) && en_q |-> !$past(run_q)); // R4
endmodule

bind clk_rate_meter clk_rate_meter_chk #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .stat_rdata(stat_rdata), .run_q(run_q), .en_q(en_q)
);

// File: tb/tb_clk_rate_meter.sv
`timescale 1ns/1ps
module tb_clk_rate_meter;
  localparam int  WIN_W = 20;
  localparam int  CNT_W = 25;
  localparam int  DIV   = 4;
  localparam real TCLK  = 20.0;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           meas_clk = 1'b0;
  logic           ctl_wr = 1'b0;
  logic [WIN_W:0] ctl_wdata = '0;
  logic [CNT_W:0] stat_rdata;

  real mhalf = 15.0;
  bit  mrun = 1'b1;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  clk_rate_meter dut (
    .clk(clk), .rst_n(rst_n), .meas_clk(meas_clk),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rdata(stat_rdata)
  );

  always #(TCLK/2) clk = ~clk;
  always begin
    #(mhalf);
    if (mrun) meas_clk = ~meas_clk;
  end

  function automatic bit flag_now();
    return stat_rdata[CNT_W];
  endfunction

  function automatic int cnt_now();
    return int'(stat_rdata[CNT_W-1:0]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int len, input bit en);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = {en, WIN_W'(len)};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_flag(input bit val, input int limit, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (flag_now() == val) seen = 1'b1;
    end
    check(seen, req, int'(flag_now()), int'(val));
  endtask

  task automatic check_rate(input int len, input string req);
    real t_win = ((len < 1) ? 1 : len) * DIV * TCLK;
    real p = 2.0 * mhalf;
    real err = cnt_now() * p - t_win;
    if (err < 0) err = -err;
    check(err <= 2.0 * p + 0.001, req, cnt_now(), int'(t_win / p));
  endtask

  // Full sequence; every cycle of the open window is compared with the model.
  task automatic measure(input int len);
    int n_win = ((len < 1) ? 1 : len) * DIV;
    wr(0, 1'b0);
    wait_flag(1'b0, 100, "R6 ready after stop");
    wr(len, 1'b0);
    wr(len, 1'b1);
    for (int i = 1; i < n_win; i++) begin
      @(negedge clk);
      check(!flag_now(), "R3 flag low in window", int'(flag_now()), 0);
    end
    wait_flag(1'b1, 200, "R4 done after window");
  endtask

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stat_rdata == '0, "R1 reset status", int'(stat_rdata), 0);

    // R2: loading a length alone starts nothing.
    wr(77, 1'b0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(!flag_now() && cnt_now() == 0, "R2 load only", cnt_now(), 0);
    end

    // R5: several measured periods and lengths.
    mhalf = 15.0;
    measure(64);
    check_rate(64, "R5 33MHz len64");
    mhalf = 7.0;
    measure(100);
    check_rate(100, "R5 71MHz len100");
    measure(0);
    check_rate(0, "R3 zero length is one tick");
    mhalf = 100.0;
    measure(500);
    check_rate(500, "R5 5MHz len500");

    // R7: dead measured clock repeats the previous count.
    prev = cnt_now();
    wr(0, 1'b0);
    wait_flag(1'b0, 100, "R6 ready before dead run");
    @(negedge meas_clk);
    mrun = 1'b0;
    measure(64);
    check(cnt_now() == prev, "R7 stale count", cnt_now(), prev);

    // R9: a second enable write does not restart the window.
    mrun = 1'b1;
    mhalf = 15.0;
    wr(0, 1'b0);
    wait_flag(1'b0, 100, "R6 ready before R9");
    wr(100, 1'b1);
    repeat (50) @(negedge clk);
    wr(400, 1'b1);
    wait_flag(1'b1, 420, "R9 original window ends");
    check_rate(100, "R9 count of original window");

    // R8 and R6: abort mid-window.
    wr(0, 1'b0);
    wait_flag(1'b0, 100, "R6 ready before abort");
    prev = cnt_now();
    wr(200, 1'b1);
    repeat (100) @(negedge clk);
    wr(0, 1'b0);
    check(flag_now(), "R6 not ready right after stop", int'(flag_now()), 1);
    wait_flag(1'b0, 50, "R6 ready after abort");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!flag_now() && cnt_now() == prev, "R8 abort keeps count", cnt_now(), prev);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule